// File: doc/BRIEF.md
# Segment Register Load Type Checker

This block judges the descriptor picked for a segment register load before the load is committed. On each load strobe it looks at the destination register, at whether the selector is null, and at the descriptor's system flag and type nibble. One cycle later it gives exactly one verdict: accept, a general-protection fault or an invalid-TSS fault, with a cause code that tells which type rule failed.

Only type rules are checked here. Privilege rules, presence, descriptor fetch and the register write itself belong to the neighbouring stages. Those stages read the verdict one cycle after the strobe and either commit the load or start the matching fault.

Top module: `seg_load_checker`

## Requirements
- R1: A verdict is registered one cycle after a cycle with `load_valid` high, and exactly one of `accept`, `gp_fault`, `ts_fault` is high in that cycle. After a cycle without a strobe all three outputs are low and `fault_cause` is 0.
- R2: Cause codes are 0 none, 1 null selector, 2 system descriptor, 3 non-code into CS, 4 execute-only code into a data register, 5 code into SS, 6 read-only data into SS, 7 undefined destination. An accept carries cause 0 and a fault carries a nonzero cause.
- R3: Destination codes are ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. Codes 6 and 7 give a general-protection fault with cause 7.
- R4: A CS load faults (general protection) on a null selector (cause 1), a system descriptor (cause 2) or a data descriptor (cause 3). Any code descriptor is accepted, whether readable or execute-only and whatever its conforming bit.
- R5: An SS load faults (general protection) on a null selector (cause 1), a system descriptor (cause 2), a code descriptor (cause 5) or a read-only data descriptor (cause 6). Writable data is accepted.
- R6: A read-only data SS load with `from_task_sw` high gives an invalid-TSS fault with cause 6 instead. In every other case `from_task_sw` has no effect on the verdict.
- R7: A DS, ES, FS or GS load with a null selector is accepted whatever the descriptor attributes are. Without a null selector it faults (general protection) on a system descriptor (cause 2) or on execute-only code (cause 4). Readable code and all data descriptors are accepted.
- R8: Rules apply in this priority: undefined destination, then null selector, then system descriptor, then the type rules.
- R9: While `rst_n` is low, all outputs are low.
- R10: Descriptor encoding: `desc_s` is 0 for a system descriptor and 1 for code or data. `desc_type` bit 3 set means code. Bit 1 means readable for code and writable for data. Bits 2 and 0 do not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_valid | input | 1 | Load strobe |
| load_dest | input | 3 | Destination register code |
| sel_null | input | 1 | Selector is null |
| desc_s | input | 1 | Descriptor system flag (0 = system) |
| desc_type | input | 4 | Descriptor type nibble |
| from_task_sw | input | 1 | Selector taken from a task-state segment during a task switch |
| accept | output | 1 | Load may be committed |
| gp_fault | output | 1 | General-protection fault |
| ts_fault | output | 1 | Invalid-TSS fault |
| fault_cause | output | 3 | Cause code of the verdict |

## Verification
The only state in the block is the verdict register, so any fault in it shows at the ports in the cycle right after the strobe. It can appear as two flags high at once, as a flag left high after an idle cycle, or as a cause that does not match the flag. A wrong class table or a wrong rule shows as a wrong verdict on the first load that reaches it. The bench therefore sweeps every destination code and every type nibble for the data registers, and it puts idle cycles between loads so that stale verdicts are seen.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    parameter int unsigned DEST_W  = 3;
    parameter int unsigned TYPE_W  = 4;
    parameter int unsigned CAUSE_W = 3;

    localparam int unsigned NUM_DEST = 2 ** DEST_W;

    // bit positions inside the type nibble
    localparam int unsigned TYPE_CODE_BIT = 3;
    localparam int unsigned TYPE_RW_BIT   = 1;

    // destination register codes
    localparam logic [DEST_W-1:0] DEST_ES = DEST_W'(0);
    localparam logic [DEST_W-1:0] DEST_CS = DEST_W'(1);
    localparam logic [DEST_W-1:0] DEST_SS = DEST_W'(2);
    localparam logic [DEST_W-1:0] DEST_DS = DEST_W'(3);
    localparam logic [DEST_W-1:0] DEST_FS = DEST_W'(4);
    localparam logic [DEST_W-1:0] DEST_GS = DEST_W'(5);

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_NULL      = 3'd1,
        CAUSE_SYSTEM    = 3'd2,
        CAUSE_NOT_CODE  = 3'd3,
        CAUSE_EXEC_ONLY = 3'd4,
        CAUSE_SS_CODE   = 3'd5,
        CAUSE_SS_RDONLY = 3'd6,
        CAUSE_BAD_DEST  = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        CLS_CODE  = 2'd0,
        CLS_STACK = 2'd1,
        CLS_DATA  = 2'd2,
        CLS_BAD   = 2'd3
    } dest_cls_e;

    typedef struct packed {
        logic   accept;
        logic   gp;
        logic   ts;
        cause_e cause;
    } verdict_t;

    function automatic dest_cls_e code_class(input int unsigned code);
        case (code)
            1:          return CLS_CODE;
            2:          return CLS_STACK;
            0, 3, 4, 5: return CLS_DATA;
            default:    return CLS_BAD;
        endcase
    endfunction

endpackage

// File: rtl/seg_dest_decode.sv
module seg_dest_decode
    import seg_chk_pkg::*;
(
    input  logic [DEST_W-1:0] dest,
    output dest_cls_e         cls
);

    dest_cls_e cls_tbl [NUM_DEST];

    // one table entry per destination code, filled at elaboration
    for (genvar g = 0; g < NUM_DEST; g++) begin : g_tbl
        assign cls_tbl[g] = code_class(g);
    end

    assign cls = cls_tbl[dest];

endmodule

// File: rtl/seg_type_rules.sv
module seg_type_rules
    import seg_chk_pkg::*;
(
    input  dest_cls_e         cls,
    input  logic              sel_null,
    input  logic              desc_s,
    input  logic [TYPE_W-1:0] desc_type,
    input  logic              from_task_sw,
    output verdict_t          verdict
);

    logic is_code;
    logic rw_bit;
    logic type_unused;

    assign is_code     = desc_type[TYPE_CODE_BIT];
    assign rw_bit      = desc_type[TYPE_RW_BIT];
    // conforming/expand-down and accessed bits do not take part
    assign type_unused = ^{desc_type[2], desc_type[0]};

    function automatic verdict_t gp_with(input cause_e c);
        verdict_t v;
        v.accept = 1'b0;
        v.gp     = 1'b1;
        v.ts     = 1'b0;
        v.cause  = c;
        return v;
    endfunction

    always_comb begin
        verdict.accept = 1'b1;
        verdict.gp     = 1'b0;
        verdict.ts     = 1'b0;
        verdict.cause  = CAUSE_NONE;
        unique case (cls)
            CLS_BAD: verdict = gp_with(CAUSE_BAD_DEST);
            CLS_CODE: begin
                if (sel_null)      verdict = gp_with(CAUSE_NULL);
                else if (!desc_s)  verdict = gp_with(CAUSE_SYSTEM);
                else if (!is_code) verdict = gp_with(CAUSE_NOT_CODE);
            end
            CLS_STACK: begin
                if (sel_null)      verdict = gp_with(CAUSE_NULL);
                else if (!desc_s)  verdict = gp_with(CAUSE_SYSTEM);
                else if (is_code)  verdict = gp_with(CAUSE_SS_CODE);
                else if (!rw_bit) begin
                    verdict = gp_with(CAUSE_SS_RDONLY);
                    if (from_task_sw) begin
                        verdict.gp = 1'b0;
                        verdict.ts = 1'b1;
                    end
                end
            end
            CLS_DATA: begin
                if (!sel_null) begin
                    if (!desc_s)                verdict = gp_with(CAUSE_SYSTEM);
                    else if (is_code && !rw_bit) verdict = gp_with(CAUSE_EXEC_ONLY);
                end
            end
            default: verdict = gp_with(CAUSE_BAD_DEST);
        endcase
    end

    // R2: a fault verdict always names a cause, an accept never does
    always_comb begin
        a_r2_cause_matches: assert (verdict.accept ? (verdict.cause == CAUSE_NONE)
                                                   : (verdict.cause != CAUSE_NONE));
    end

endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
    import seg_chk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_valid,
    input  logic [DEST_W-1:0]  load_dest,
    input  logic               sel_null,
    input  logic               desc_s,
    input  logic [TYPE_W-1:0]  desc_type,
    input  logic               from_task_sw,
    output logic               accept,
    output logic               gp_fault,
    output logic               ts_fault,
    output logic [CAUSE_W-1:0] fault_cause
);

    dest_cls_e cls;
    verdict_t  rule_v;
    verdict_t  state_d;
    verdict_t  state_q;

    seg_dest_decode i_decode (
        .dest (load_dest),
        .cls  (cls)
    );

    seg_type_rules i_rules (
        .cls          (cls),
        .sel_null     (sel_null),
        .desc_s       (desc_s),
        .desc_type    (desc_type),
        .from_task_sw (from_task_sw),
        .verdict      (rule_v)
    );

    always_comb begin
        state_d = '0;
        if (load_valid) begin
            state_d = rule_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign accept      = state_q.accept;
    assign gp_fault    = state_q.gp;
    assign ts_fault    = state_q.ts;
    assign fault_cause = state_q.cause;

    // R1: one verdict per strobe, silence otherwise
    a_r1_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> ($countones({accept, gp_fault, ts_fault}) == 1));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |=> (!accept && !gp_fault && !ts_fault && fault_cause == '0));

    // R3: undefined destination codes fault
    a_r3_bad_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_dest > DEST_GS) |=> (gp_fault && fault_cause == CAUSE_BAD_DEST));

    // R4: null selector into CS
    a_r4_cs_null: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_dest == DEST_CS && sel_null) |=> (gp_fault && fault_cause == CAUSE_NULL));

    // R6: invalid-TSS only for SS loads during a task switch
    a_r6_ts_scope: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && !(from_task_sw && load_dest == DEST_SS)) |=> !ts_fault);

    // R7: null selector into a data register is accepted
    a_r7_data_null_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && sel_null && (load_dest == DEST_ES || load_dest == DEST_DS ||
         load_dest == DEST_FS || load_dest == DEST_GS)) |=> accept);

endmodule

// File: tb/test_seg_load_checker.sv
`timescale 1ns/1ps
module test_seg_load_checker;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         stamp;
        logic       acc;
        logic       gp;
        logic       ts;
        logic [2:0] cause;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_valid = 1'b0;
    logic [2:0] load_dest = '0;
    logic       sel_null = 1'b0;
    logic       desc_s = 1'b0;
    logic [3:0] desc_type = '0;
    logic       from_task_sw = 1'b0;
    logic       accept;
    logic       gp_fault;
    logic       ts_fault;
    logic [2:0] fault_cause;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sbq[$];

    seg_load_checker i_seg_load_checker (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_valid   (load_valid),
        .load_dest    (load_dest),
        .sel_null     (sel_null),
        .desc_s       (desc_s),
        .desc_type    (desc_type),
        .from_task_sw (from_task_sw),
        .accept       (accept),
        .gp_fault     (gp_fault),
        .ts_fault     (ts_fault),
        .fault_cause  (fault_cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic compare(input exp_t e);
        checks++;
        if (accept !== e.acc || gp_fault !== e.gp || ts_fault !== e.ts || fault_cause !== e.cause) begin
            failures++;
            $display("FAIL %s: actual acc=%0b gp=%0b ts=%0b cause=%0d expected acc=%0b gp=%0b ts=%0b cause=%0d",
                     e.req, accept, gp_fault, ts_fault, fault_cause, e.acc, e.gp, e.ts, e.cause);
        end
    endtask

    // monitor: a load driven in stamp n is visible after the capture edge of n+1
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0 && sbq[0].stamp == cyc - 1) begin
                compare(sbq.pop_front());
            end
        end
    end

    task automatic drive(input logic v, input logic [2:0] d, input logic nul, input logic s,
                         input logic [3:0] t, input logic tsw,
                         input logic ea, input logic eg, input logic et, input logic [2:0] ec,
                         input string req);
        exp_t e;
        @(posedge clk);
        #1;
        load_valid   = v;
        load_dest    = d;
        sel_null     = nul;
        desc_s       = s;
        desc_type    = t;
        from_task_sw = tsw;
        e.stamp = cyc;
        e.acc = ea; e.gp = eg; e.ts = et; e.cause = ec; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic load(input logic [2:0] d, input logic nul, input logic s, input logic [3:0] t,
                        input logic tsw, input logic ea, input logic eg, input logic et,
                        input logic [2:0] ec, input string req);
        drive(1'b1, d, nul, s, t, tsw, ea, eg, et, ec, req);
    endtask

    // idle with junk attributes: nothing may appear (R1)
    task automatic idle();
        drive(1'b0, 3'd2, 1'b1, 1'b0, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, "R1 idle");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: outputs low under reset even with a strobe present
        load_valid = 1'b1;
        load_dest  = 3'd1;
        sel_null   = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (accept !== 1'b0 || gp_fault !== 1'b0 || ts_fault !== 1'b0 || fault_cause !== 3'd0) begin
            failures++;
            $display("FAIL R9: actual acc=%0b gp=%0b ts=%0b cause=%0d expected all 0",
                     accept, gp_fault, ts_fault, fault_cause);
        end
        load_valid = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;

        idle();
        // R4: CS rules
        load(3'd1, 1, 1, 4'b1010, 0, 0, 1, 0, 3'd1, "R4 cs null");
        load(3'd1, 0, 0, 4'b1011, 0, 0, 1, 0, 3'd2, "R4 cs system");
        load(3'd1, 0, 1, 4'b0010, 0, 0, 1, 0, 3'd3, "R4 cs data");
        load(3'd1, 0, 1, 4'b1000, 0, 1, 0, 0, 3'd0, "R4 cs exec-only");
        load(3'd1, 0, 1, 4'b1110, 0, 1, 0, 0, 3'd0, "R4 cs conforming readable");
        idle();
        // R5: SS rules
        load(3'd2, 1, 1, 4'b0010, 0, 0, 1, 0, 3'd1, "R5 ss null");
        load(3'd2, 0, 0, 4'b0010, 0, 0, 1, 0, 3'd2, "R5 ss system");
        load(3'd2, 0, 1, 4'b1010, 0, 0, 1, 0, 3'd5, "R5 ss code");
        load(3'd2, 0, 1, 4'b0000, 0, 0, 1, 0, 3'd6, "R5 ss read-only");
        load(3'd2, 0, 1, 4'b0010, 0, 1, 0, 0, 3'd0, "R5 ss writable");
        load(3'd2, 0, 1, 4'b0111, 0, 1, 0, 0, 3'd0, "R10 ss expand-down writable");
        idle();
        // R6: task-switch origin
        load(3'd2, 0, 1, 4'b0000, 1, 0, 0, 1, 3'd6, "R6 ss read-only task switch");
        load(3'd2, 0, 1, 4'b0101, 1, 0, 0, 1, 3'd6, "R6 ss read-only task switch alt bits");
        load(3'd2, 0, 1, 4'b0010, 1, 1, 0, 0, 3'd0, "R6 ss writable task switch");
        load(3'd2, 1, 1, 4'b0000, 1, 0, 1, 0, 3'd1, "R6 ss null task switch");
        load(3'd2, 0, 1, 4'b1000, 1, 0, 1, 0, 3'd5, "R6 ss code task switch");
        load(3'd3, 0, 1, 4'b1000, 1, 0, 1, 0, 3'd4, "R6 ds exec-only task switch");
        idle();
        // R7: data registers
        load(3'd3, 1, 0, 4'b1111, 0, 1, 0, 0, 3'd0, "R7 ds null with system attrs");
        load(3'd0, 0, 0, 4'b0010, 0, 0, 1, 0, 3'd2, "R7 es system");
        load(3'd4, 0, 1, 4'b1001, 0, 0, 1, 0, 3'd4, "R7 fs exec-only");
        load(3'd5, 0, 1, 4'b1010, 0, 1, 0, 0, 3'd0, "R7 gs readable code");
        load(3'd0, 0, 1, 4'b0000, 0, 1, 0, 0, 3'd0, "R7 es read-only data");
        idle();
        // R3: undefined destinations
        load(3'd6, 0, 1, 4'b0010, 0, 0, 1, 0, 3'd7, "R3 dest 6");
        load(3'd7, 1, 0, 4'b0000, 1, 0, 1, 0, 3'd7, "R3 dest 7 null");
        // R8: priorities
        load(3'd2, 1, 0, 4'b1000, 0, 0, 1, 0, 3'd1, "R8 null over system");
        load(3'd2, 0, 0, 4'b1000, 0, 0, 1, 0, 3'd2, "R8 system over type");
        load(3'd1, 1, 0, 4'b0000, 0, 0, 1, 0, 3'd1, "R8 cs null over system");
        idle();
        // R2, R10: sweep data registers over all type nibbles
        for (int r = 0; r < 4; r++) begin
            logic [2:0] dr;
            dr = (r == 0) ? 3'd0 : 3'(r + 2);
            for (int t = 0; t < 16; t++) begin
                logic [3:0] tv;
                logic xo;
                tv = 4'(t);
                xo = tv[3] && !tv[1];
                load(dr, 0, 1, tv, 0, !xo, xo, 0, xo ? 3'd4 : 3'd0, "R2 R10 data sweep");
            end
        end
        idle();
        idle();
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule